// File: doc/BRIEF.md
# DTMF Tone Pair Frequency Classifier

This block sits after the analog front end of a touch-tone receiver. It takes two hard-limited square waves, one carrying the low-group tone and one carrying the high-group tone, and a free-running reference clock. It measures the time between successive edges of each wave by counting reference-clock cycles. It adds the most recent four half-period spans and compares that sum against the expected sum for each of the four standard frequencies of the group. The acceptance window is ±2.5% of each expected sum.

When both groups hold a recognised frequency at the same time, the block raises an early-steering flag. It also presents the 4-bit key code of the pair. The flag falls as soon as either group loses its tone. A group loses its tone when a fresh averaged measurement falls outside every window, or when the input shows no edge for longer than a timeout. An inhibit input blocks the fourth high-group column, 1633 Hz, from being accepted.

Duration checking and output latching belong to a separate steering block that watches the flag. Both square-wave inputs are asynchronous to the reference clock, so each one passes through a two-flop synchronizer.

Top module: `dtmf_pair_classifier`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `early_o` is 0 and `key_o` is 4'b0000.
- R2: The low-group frequencies 697, 770, 852 and 941 Hz are recognised as rows 0 to 3. A tone whose averaged four-half-period sum lies within ±2.5% of the nominal sum is accepted; for example, a 697 Hz row tone running about 1.7% slow is accepted.
- R3: The high-group frequencies 1209, 1336, 1477 and 1633 Hz are recognised as columns 0 to 3, with the same ±2.5% window on the four-half-period sum.
- R4: The key code is decoded from row and column. Rows 0 to 2 with columns 0 to 2 give the codes row*3+col+1, which are 1 to 9. Row 3 gives 4'b1011 for column 0, 4'b1010 for column 1 and 4'b1100 for column 2.
- R5: Column 3 gives 4'b1101, 4'b1110 and 4'b1111 for rows 0, 1 and 2, and 4'b0000 for row 3.
- R6: `early_o` is high only while both groups hold a valid tone. While `early_o` is low, `key_o` is 4'b0000.
- R7: A tone whose sum lies outside the window of every nominal frequency is rejected. This holds for a low or a high tone about 5% off a nominal frequency, or about 6% off a nominal frequency.
- R8: A group that shows no input edge for more than 5/4 of the nominal half period of its lowest frequency becomes invalid at once, and `early_o` falls.
- R9: An edge whose averaged sum no longer matches any window makes its group invalid at that edge. The block does not wait for the timeout.
- R10: While `inhibit_i` is 1, a column-3 high tone is not valid. The inhibit acts in the same cycle in both directions, and no re-measurement is needed when it is released.
- R11: A group becomes valid only after five input edges following reset or a timeout. The first edge only starts the measurement, and four complete spans are then needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; every measurement counts its cycles |
| rst | input | 1 | Synchronous active-high reset |
| low_sq_i | input | 1 | Limited low-group tone, asynchronous |
| high_sq_i | input | 1 | Limited high-group tone, asynchronous |
| inhibit_i | input | 1 | 1 = reject the 1633 Hz column |
| early_o | output | 1 | Early-steering flag: both groups hold a valid tone |
| key_o | output | 4 | Key code of the detected pair, 0 when `early_o` is low |

## Verification
Two functions can land in the same cycle. One is the inhibit gating. The other is a high-group classification that is already holding column 3. The bench first holds key B until the flag is up. It then raises `inhibit_i` just after a clock edge and expects the flag to be low and the code to be zero one edge later. Dropping inhibit must bring back key B on the very next sample, without waiting for new edges. A checker property also requires every rising flag to trace back either to a measurement edge in the previous cycle or to inhibit falling in the same cycle. This ties the two causes together cycle by cycle.

// File: rtl/dtmf_cls_pkg.sv
package dtmf_cls_pkg;

    localparam int GROUPS = 2;
    localparam int TONES  = 4;

    // One group's current verdict: a recognised tone and its row/column index
    typedef struct packed {
        logic       ok;
        logic [1:0] idx;
    } tone_t;

    // Nominal frequency of tone k in group grp (0 = low rows, 1 = high columns)
    function automatic int tone_hz(input int grp, input int k);
        int f;
        if (grp == 0) begin
            case (k)
                0:       f = 697;
                1:       f = 770;
                2:       f = 852;
                default: f = 941;
            endcase
        end else begin
            case (k)
                0:       f = 1209;
                1:       f = 1336;
                2:       f = 1477;
                default: f = 1633;
            endcase
        end
        return f;
    endfunction

    // Rounded half period in reference cycles
    function automatic int half_cycles(input int clk_hz, input int f);
        return (clk_hz + f) / (2 * f);
    endfunction

    // Rounded sum of avg_n half periods
    function automatic int nominal_sum(input int clk_hz, input int f, input int avg_n);
        return (avg_n * clk_hz + f) / (2 * f);
    endfunction

    // Silence limit: 5/4 of the longest half period in the group
    function automatic int quiet_limit(input int clk_hz, input int grp);
        return (half_cycles(clk_hz, tone_hz(grp, 0)) * 5) / 4;
    endfunction

    // Row/column to 4-bit key code
    function automatic logic [3:0] key_code(input logic [1:0] row, input logic [1:0] col);
        logic [3:0] c;
        if (col == 2'd3) begin
            c = (row == 2'd3) ? 4'd0 : 4'd13 + 4'(row);
        end else if (row == 2'd3) begin
            case (col)
                2'd0:    c = 4'd11;
                2'd1:    c = 4'd10;
                default: c = 4'd12;
            endcase
        end else begin
            c = 4'(row) * 4'd3 + 4'(col) + 4'd1;
        end
        return c;
    endfunction

endpackage

// File: rtl/dtmf_cls_sync.sv
module dtmf_cls_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q_o  <= '0;
        end else begin
            meta <= d_i;
            q_o  <= meta;
        end
    end

endmodule

// File: rtl/dtmf_cls_match.sv
module dtmf_cls_match
    import dtmf_cls_pkg::*;
#(
    parameter int CLK_HZ     = 3579545,
    parameter int GROUP      = 0,
    parameter int AVG_N      = 4,
    parameter int TOL_PERMIL = 25,
    parameter int SUM_W      = 16
) (
    input  logic [SUM_W-1:0] sum_i,
    output tone_t            tone_o
);

    logic [TONES-1:0] hit;

    for (genvar k = 0; k < TONES; k++) begin : g_win
        localparam int NOM = nominal_sum(CLK_HZ, tone_hz(GROUP, k), AVG_N);
        localparam int TOL = (NOM * TOL_PERMIL) / 1000;
        localparam logic [SUM_W:0] LO_B = (SUM_W+1)'(NOM - TOL);
        localparam logic [SUM_W:0] HI_B = (SUM_W+1)'(NOM + TOL);
        assign hit[k] = ({1'b0, sum_i} >= LO_B) && ({1'b0, sum_i} <= HI_B);
    end

    // Windows are disjoint; the loop just encodes the single hit
    always_comb begin
        tone_o = '0;
        for (int k = 0; k < TONES; k++) begin
            if (hit[k]) begin
                tone_o.ok  = 1'b1;
                tone_o.idx = 2'(k);
            end
        end
    end

endmodule

// File: rtl/dtmf_cls_meter.sv
module dtmf_cls_meter
    import dtmf_cls_pkg::*;
#(
    parameter int CLK_HZ     = 3579545,
    parameter int GROUP      = 0,
    parameter int AVG_N      = 4,
    parameter int TOL_PERMIL = 25
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sq_i,
    output logic  edge_o,
    output tone_t tone_o
);

    localparam int QUIET  = quiet_limit(CLK_HZ, GROUP);
    localparam int CNT_W  = $clog2(QUIET + 2);
    localparam int SUM_W  = CNT_W + $clog2(AVG_N);
    localparam int FILL_W = $clog2(AVG_N + 1);

    logic               sq_q;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   span;
    logic [CNT_W-1:0]   hist [AVG_N-1];
    logic [FILL_W-1:0]  fill;
    logic [SUM_W-1:0]   sum;
    tone_t              cand;

    assign edge_o = sq_i ^ sq_q;
    assign span   = cnt + CNT_W'(1);

    // Current span plus the AVG_N-1 previous spans
    always_comb begin
        sum = SUM_W'(span);
        for (int i = 0; i < AVG_N - 1; i++) begin
            sum = sum + SUM_W'(hist[i]);
        end
    end

    dtmf_cls_match #(
        .CLK_HZ    (CLK_HZ),
        .GROUP     (GROUP),
        .AVG_N     (AVG_N),
        .TOL_PERMIL(TOL_PERMIL),
        .SUM_W     (SUM_W)
    ) u_match (
        .sum_i (sum),
        .tone_o(cand)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sq_q   <= 1'b0;
            cnt    <= '0;
            fill   <= '0;
            tone_o <= '0;
            for (int i = 0; i < AVG_N - 1; i++) hist[i] <= '0;
        end else begin
            sq_q <= sq_i;
            if (edge_o) begin
                cnt     <= '0;
                hist[0] <= span;
                for (int i = 1; i < AVG_N - 1; i++) hist[i] <= hist[i-1];
                tone_o  <= (fill >= FILL_W'(AVG_N)) ? cand : '0;
                if (fill < FILL_W'(AVG_N)) fill <= fill + FILL_W'(1);
            end else if (cnt >= CNT_W'(QUIET)) begin
                fill   <= '0;
                tone_o <= '0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/dtmf_pair_classifier.sv
module dtmf_pair_classifier
    import dtmf_cls_pkg::*;
#(
    parameter int CLK_HZ     = 3579545,
    parameter int AVG_N      = 4,
    parameter int TOL_PERMIL = 25
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       low_sq_i,
    input  logic       high_sq_i,
    input  logic       inhibit_i,
    output logic       early_o,
    output logic [3:0] key_o
);

    logic [GROUPS-1:0] sq_sync;
    logic [GROUPS-1:0] grp_edge;
    tone_t             grp_tone [GROUPS];
    logic              high_ok;

    dtmf_cls_sync #(.W(GROUPS)) u_sync (
        .clk(clk),
        .rst(rst),
        .d_i({high_sq_i, low_sq_i}),
        .q_o(sq_sync)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        dtmf_cls_meter #(
            .CLK_HZ    (CLK_HZ),
            .GROUP     (g),
            .AVG_N     (AVG_N),
            .TOL_PERMIL(TOL_PERMIL)
        ) u_meter (
            .clk   (clk),
            .rst   (rst),
            .sq_i  (sq_sync[g]),
            .edge_o(grp_edge[g]),
            .tone_o(grp_tone[g])
        );
    end

    assign high_ok = grp_tone[1].ok && !(inhibit_i && (grp_tone[1].idx == 2'd3));
    assign early_o = grp_tone[0].ok && high_ok;
    assign key_o   = early_o ? key_code(grp_tone[0].idx, grp_tone[1].idx) : 4'd0;

endmodule

// File: rtl/dtmf_pair_classifier_chk.sv
module dtmf_pair_classifier_chk
    import dtmf_cls_pkg::*;
#(
    parameter int CLK_HZ = 3579545
) (
    input logic       clk,
    input logic       rst,
    input logic       inhibit_i,
    input logic       early_o,
    input logic [3:0] key_o,
    input logic [1:0] grp_edge
);

    localparam int Q_LO = quiet_limit(CLK_HZ, 0);
    localparam int Q_HI = quiet_limit(CLK_HZ, 1);

    logic [15:0] idle_lo, idle_hi;
    logic        rst_d  = 1'b0;
    logic        primed = 1'b0;

    always_ff @(posedge clk) begin
        rst_d  <= rst;
        primed <= 1'b1;
        if (rst || grp_edge[0]) idle_lo <= '0;
        else if (idle_lo <= 16'(Q_LO)) idle_lo <= idle_lo + 16'd1;
        if (rst || grp_edge[1]) idle_hi <= '0;
        else if (idle_hi <= 16'(Q_HI)) idle_hi <= idle_hi + 16'd1;
    end

    // R1: the cycle after reset is seen, the flag is clear
    always @(posedge clk) begin
        if (primed && rst_d) begin
            p_reset_clear_r1: assert (!early_o && key_o == 4'd0)
                else $error("early/key not clear after reset");
        end
    end

    p_idle_key_r6: assert property (@(posedge clk) disable iff (rst)
        !early_o |-> (key_o == 4'd0));

    p_inhibit_col4_r10: assert property (@(posedge clk) disable iff (rst)
        (inhibit_i && early_o) |-> (key_o inside {[4'd1:4'd12]}));

    p_rise_cause_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(early_o) |-> ($past(|grp_edge) || $fell(inhibit_i)));

    p_quiet_low_r8: assert property (@(posedge clk) disable iff (rst)
        (idle_lo > 16'(Q_LO)) |-> !early_o);

    p_quiet_high_r8: assert property (@(posedge clk) disable iff (rst)
        (idle_hi > 16'(Q_HI)) |-> !early_o);

endmodule

bind dtmf_pair_classifier dtmf_pair_classifier_chk #(.CLK_HZ(CLK_HZ)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .inhibit_i(inhibit_i),
    .early_o  (early_o),
    .key_o    (key_o),
    .grp_edge (grp_edge)
);

// File: tb/dtmf_pair_classifier_test.sv
module dtmf_pair_classifier_test;

    localparam int CLK_PERIOD = 10;
    localparam int REF_HZ     = 400000;

    // {row[9:8], col[7:6], inhibit[5], exp_early[4], exp_key[3:0]}
    localparam logic [9:0] VEC [18] = '{
        {2'd0, 2'd0, 1'b0, 1'b1, 4'b0001},
        {2'd0, 2'd1, 1'b0, 1'b1, 4'b0010},
        {2'd0, 2'd2, 1'b0, 1'b1, 4'b0011},
        {2'd0, 2'd3, 1'b0, 1'b1, 4'b1101},
        {2'd1, 2'd0, 1'b0, 1'b1, 4'b0100},
        {2'd1, 2'd1, 1'b0, 1'b1, 4'b0101},
        {2'd1, 2'd2, 1'b0, 1'b1, 4'b0110},
        {2'd1, 2'd3, 1'b0, 1'b1, 4'b1110},
        {2'd2, 2'd0, 1'b0, 1'b1, 4'b0111},
        {2'd2, 2'd1, 1'b0, 1'b1, 4'b1000},
        {2'd2, 2'd2, 1'b0, 1'b1, 4'b1001},
        {2'd2, 2'd3, 1'b0, 1'b1, 4'b1111},
        {2'd3, 2'd0, 1'b0, 1'b1, 4'b1011},
        {2'd3, 2'd1, 1'b0, 1'b1, 4'b1010},
        {2'd3, 2'd2, 1'b0, 1'b1, 4'b1100},
        {2'd3, 2'd3, 1'b0, 1'b1, 4'b0000},
        {2'd0, 2'd3, 1'b1, 1'b0, 4'b0000},
        {2'd0, 2'd0, 1'b1, 1'b1, 4'b0001}
    };

    localparam int ROW_HZ [4] = '{697, 770, 852, 941};
    localparam int COL_HZ [4] = '{1209, 1336, 1477, 1633};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lo_sq = 1'b0;
    logic       hi_sq = 1'b0;
    logic       inh = 1'b0;
    logic       early;
    logic [3:0] key;

    int lo_half = 0;
    int hi_half = 0;
    int n_chk   = 0;
    int n_bad   = 0;

    dtmf_pair_classifier #(.CLK_HZ(REF_HZ)) uut (
        .clk      (clk),
        .rst      (rst),
        .low_sq_i (lo_sq),
        .high_sq_i(hi_sq),
        .inhibit_i(inh),
        .early_o  (early),
        .key_o    (key)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial forever begin
        if (lo_half == 0) @(negedge clk);
        else begin
            repeat (lo_half) @(negedge clk);
            lo_sq = ~lo_sq;
        end
    end

    initial forever begin
        if (hi_half == 0) @(negedge clk);
        else begin
            repeat (hi_half) @(negedge clk);
            hi_sq = ~hi_sq;
        end
    end

    function automatic int half_of(input int f);
        return (REF_HZ + f) / (2 * f);
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic exp_e, input logic [3:0] exp_k);
        n_chk++;
        if (early !== exp_e || key !== exp_k) begin
            n_bad++;
            $display("FAIL %s: early=%b key=%b, expected early=%b key=%b",
                     req, early, key, exp_e, exp_k);
        end
    endtask

    task automatic silence();
        lo_half = 0;
        hi_half = 0;
        wait_n(800);
    endtask

    task automatic play(input int row, input int col);
        lo_half = half_of(ROW_HZ[row]);
        hi_half = half_of(COL_HZ[col]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait_n(4);
        check("R1 during reset", 1'b0, 4'd0);
        rst = 1'b0;
        wait_n(1);
        check("R1 after reset", 1'b0, 4'd0);

        // Table: every key, plus inhibit on column 3 and on column 0
        for (int v = 0; v < 18; v++) begin
            logic [9:0] e;
            string tag;
            e = VEC[v];
            silence();
            inh = e[5];
            play(int'(e[9:8]), int'(e[7:6]));
            wait_n(1700);
            tag = (e[7:6] == 2'd3) ? (e[5] ? "R10 table" : "R5 table") : "R4 table";
            check(tag, e[4], e[3:0]);
        end
        inh = 1'b0;

        // R11: five edges needed before a group is valid
        silence();
        play(0, 0);
        wait_n(1200);
        check("R11 before fifth low edge", 1'b0, 4'd0);
        wait_n(300);
        check("R11 after fifth low edge", 1'b1, 4'b0001);

        // R2: low tone about 1.7% slow still accepted
        silence();
        lo_half = 292;
        hi_half = half_of(1336);
        wait_n(1700);
        check("R2 low within window", 1'b1, 4'b0010);

        // R3: high tone about 1.8% slow still accepted
        silence();
        lo_half = half_of(770);
        hi_half = 168;
        wait_n(1700);
        check("R3 high within window", 1'b1, 4'b0100);

        // R7: off-frequency low and off-frequency high rejected
        silence();
        lo_half = 304;
        hi_half = half_of(1209);
        wait_n(2000);
        check("R7 low off-frequency", 1'b0, 4'd0);
        silence();
        lo_half = half_of(852);
        hi_half = 158;
        wait_n(2000);
        check("R7 high off-frequency", 1'b0, 4'd0);

        // R6: only one group present
        silence();
        lo_half = half_of(941);
        wait_n(1700);
        check("R6 low only", 1'b0, 4'd0);

        // R9: mismatching span drops the group before the quiet limit
        silence();
        play(1, 1);
        wait_n(1700);
        check("R4 key 5 held", 1'b1, 4'b0101);
        lo_half = 304;
        wait_n(620);
        check("R9 drop on mismatch", 1'b0, 4'd0);

        // R8: high input stops toggling
        silence();
        play(2, 2);
        wait_n(1700);
        check("R8 key 9 held", 1'b1, 4'b1001);
        hi_half = 0;
        wait_n(400);
        check("R8 drop on quiet high", 1'b0, 4'd0);

        // R10: live inhibit toggle on a held column-3 key
        silence();
        play(1, 3);
        wait_n(1700);
        check("R10 key B held", 1'b1, 4'b1110);
        inh = 1'b1;
        wait_n(1);
        check("R10 inhibit raised", 1'b0, 4'd0);
        inh = 1'b0;
        wait_n(1);
        check("R10 inhibit released", 1'b1, 4'b1110);

        silence();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule